// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical address after a translation-cache miss. It walks a two-level table: a directory entry is read from the directory that a base address points to, then a table entry is read from the table that the directory entry names. Both reads are single-word transactions on a valid/ready request channel, with read data returned later on a response strobe.

At each level the walker checks the present bit first. A directory entry that asks for a large page is then flagged as unsupported. Finally the supervisor and read-only permissions are checked against the access type. If the walk gets past the checks but the accessed bit or, for a write, the table entry's dirty bit is clear in memory, the walker writes the updated entry back before it goes on. The walk ends with a one-cycle result pulse. The result is either a physical address plus the final table entry for the translation cache, a page fault, or an unsupported-size error. A page fault says whether the page was missing or the access was forbidden, whether it was a write, and whether it came from user mode.

Top module: `pt_walker`

## Requirements
- R1: A walk accepted with directory base B reads the directory entry at word address B + 4 × VA[31:22]. The read is a request with mem_req_write = 0.
- R2: The table entry is read at {directory entry[31:12], VA[21:12], 2'b00}. A completed walk reports done_paddr = {table entry[31:12], VA[11:0]}.
- R3: If entry bit 0 (present) is 0 at either level, the walk ends with fault_valid = 1, fault_prot = 0 and fault_vaddr = VA. No further memory request is issued. This check comes before every other check at that level.
- R4: If entry bit 2 (user allowed) is 0 on a user access, or entry bit 1 (writable) is 0 on a write, at either level, the walk ends with fault_valid = 1 and fault_prot = 1. fault_write and fault_user echo the access type.
- R5: A present directory entry with bit 7 (large page) set ends the walk with a size_err pulse and fault_vaddr = VA. It gives no translation and no table read. This check comes before the permission checks.
- R6: If a directory entry passes its checks with bit 5 (accessed) at 0, it is written back to the same address with bit 5 set. This write happens before the table read.
- R7: If a table entry passes its checks with bit 5 at 0, or with bit 6 (dirty) at 0 on a write, it is written back with bit 5 set and, on a write, bit 6 set. The walk does not complete until that write is accepted. Entries that already hold those bits are not written.
- R8: A successful walk gives a single-cycle done_valid pulse. done_entry carries the table entry with any accessed/dirty updates applied.
- R9: busy is 1 from the cycle after a request is accepted until the cycle in which the result pulse appears, where it is 0. Requests presented while busy are ignored, and no memory request is made while idle.
- R10: A memory request, with its address, direction and data, is held unchanged until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | 4 KB-aligned directory base address |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Word address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 32 | Read data |
| done_valid | output | 1 | Translation result pulse |
| done_paddr | output | 32 | Translated physical address |
| done_entry | output | 32 | Final table entry for the translation cache |
| fault_valid | output | 1 | Page fault pulse |
| fault_prot | output | 1 | 1 = protection violation, 0 = not present |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was from user mode |
| fault_vaddr | output | 32 | Address of the failed walk (fault or size error) |
| size_err | output | 1 | Large-page directory entry pulse |

## Verification
The walks cover clean entries with both accessed bits already set, which gives pure reads with no write-back. They cover entries with clear accessed bits at both levels and writes to clean pages, which separates the directory and table write-back paths and the dirty update. Writes to pages that are already dirty show that redundant writes are suppressed. The fault cases combine a missing directory, a missing table entry, a user access to a supervisor page and a write to a read-only directory, together with entries that are both non-present and large or both non-present and forbidden. These last two tell apart the order of the present, size and permission checks. One walk runs with a different request held on the input the whole time, to show that it cannot disturb a walk in progress, and the memory side stalls ready on a fixed pattern so that held requests are exercised.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int BASE_W = VA_W - OFF_W;

    localparam int BIT_PRES  = 0;
    localparam int BIT_WRITE = 1;
    localparam int BIT_USER  = 2;
    localparam int BIT_ACC   = 5;
    localparam int BIT_DIRTY = 6;
    localparam int BIT_LARGE = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_DIR_WB,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_TBL_WB
    } walk_st_e;

    typedef enum logic [1:0] {
        CHK_OK,
        CHK_ABSENT,
        CHK_LARGE,
        CHK_DENIED
    } chk_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic            wr;
        logic            usr;
        logic [VA_W-1:0] base;
    } walk_ctx_t;

    function automatic logic [IDX_W-1:0] dir_index(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] tbl_index(input logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [OFF_W-1:0] page_off(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/pw_entry_check.sv
module pw_entry_check
    import pw_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            is_dir,
    input  logic            wr,
    input  logic            usr,
    output chk_e            verdict
);
    logic denied;

    always_comb begin
        denied = (usr && !entry[BIT_USER]) || (wr && !entry[BIT_WRITE]);
        if (!entry[BIT_PRES])
            verdict = CHK_ABSENT;
        else if (is_dir && entry[BIT_LARGE])
            verdict = CHK_LARGE;
        else if (denied)
            verdict = CHK_DENIED;
        else
            verdict = CHK_OK;
    end
endmodule

// File: rtl/pw_entry_update.sv
module pw_entry_update
    import pw_pkg::*;
(
    input  logic [VA_W-1:0] entry,
    input  logic            is_dir,
    input  logic            wr,
    output logic [VA_W-1:0] new_entry,
    output logic            need_wb
);
    always_comb begin
        new_entry          = entry;
        new_entry[BIT_ACC] = 1'b1;
        if (!is_dir && wr)
            new_entry[BIT_DIRTY] = 1'b1;
        need_wb = (new_entry != entry);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic [31:0] dir_base,
    output logic        busy,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    output logic        done_valid,
    output logic [31:0] done_paddr,
    output logic [31:0] done_entry,
    output logic        fault_valid,
    output logic        fault_prot,
    output logic        fault_write,
    output logic        fault_user,
    output logic [31:0] fault_vaddr,
    output logic        size_err
);
    walk_st_e        state;
    walk_ctx_t       ctx;
    logic [VA_W-1:0] dir_ent_q;
    logic [VA_W-1:0] tbl_ent_q;

    logic            at_dir;
    chk_e            verdict;
    logic [VA_W-1:0] upd_entry;
    logic            upd_need;
    logic [VA_W-1:0] dir_addr;
    logic [VA_W-1:0] tbl_addr;

    assign at_dir   = (state == ST_DIR_WAIT);
    assign dir_addr = ctx.base + {{(VA_W-IDX_W-2){1'b0}}, dir_index(ctx.va), 2'b00};
    assign tbl_addr = {dir_ent_q[VA_W-1:OFF_W], tbl_index(ctx.va), 2'b00};
    assign busy     = (state != ST_IDLE);

    pw_entry_check u_check (
        .entry   (mem_rsp_rdata),
        .is_dir  (at_dir),
        .wr      (ctx.wr),
        .usr     (ctx.usr),
        .verdict (verdict)
    );

    pw_entry_update u_update (
        .entry     (mem_rsp_rdata),
        .is_dir    (at_dir),
        .wr        (ctx.wr),
        .new_entry (upd_entry),
        .need_wb   (upd_need)
    );

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (state)
            ST_DIR_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = dir_addr;
            end
            ST_DIR_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dir_addr;
                mem_req_wdata = dir_ent_q;
            end
            ST_TBL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = tbl_addr;
            end
            ST_TBL_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = tbl_addr;
                mem_req_wdata = tbl_ent_q;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ctx         <= '0;
            dir_ent_q   <= '0;
            tbl_ent_q   <= '0;
            done_valid  <= 1'b0;
            done_paddr  <= '0;
            done_entry  <= '0;
            fault_valid <= 1'b0;
            fault_prot  <= 1'b0;
            fault_write <= 1'b0;
            fault_user  <= 1'b0;
            fault_vaddr <= '0;
            size_err    <= 1'b0;
        end else begin
            done_valid  <= 1'b0;
            fault_valid <= 1'b0;
            size_err    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx.va   <= req_vaddr;
                        ctx.wr   <= req_write;
                        ctx.usr  <= req_user;
                        ctx.base <= dir_base;
                        state    <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: if (mem_req_ready) state <= ST_DIR_WAIT;
                ST_TBL_REQ: if (mem_req_ready) state <= ST_TBL_WAIT;
                ST_DIR_WB:  if (mem_req_ready) state <= ST_TBL_REQ;
                ST_DIR_WAIT, ST_TBL_WAIT: begin
                    if (mem_rsp_valid) begin
                        unique case (verdict)
                            CHK_OK: begin
                                if (at_dir) begin
                                    dir_ent_q <= upd_entry;
                                    state     <= upd_need ? ST_DIR_WB : ST_TBL_REQ;
                                end else begin
                                    tbl_ent_q <= upd_entry;
                                    if (upd_need) begin
                                        state <= ST_TBL_WB;
                                    end else begin
                                        state      <= ST_IDLE;
                                        done_valid <= 1'b1;
                                        done_entry <= upd_entry;
                                        done_paddr <= {upd_entry[VA_W-1:OFF_W], page_off(ctx.va)};
                                    end
                                end
                            end
                            CHK_LARGE: begin
                                state       <= ST_IDLE;
                                size_err    <= 1'b1;
                                fault_vaddr <= ctx.va;
                            end
                            default: begin
                                state       <= ST_IDLE;
                                fault_valid <= 1'b1;
                                fault_prot  <= (verdict == CHK_DENIED);
                                fault_write <= ctx.wr;
                                fault_user  <= ctx.usr;
                                fault_vaddr <= ctx.va;
                            end
                        endcase
                    end
                end
                ST_TBL_WB: begin
                    if (mem_req_ready) begin
                        state      <= ST_IDLE;
                        done_valid <= 1'b1;
                        done_entry <= tbl_ent_q;
                        done_paddr <= {tbl_ent_q[VA_W-1:OFF_W], page_off(ctx.va)};
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic        done_valid,
    input logic        fault_valid,
    input logic        size_err
);
    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy |=> busy);

    a_r9_result_idle: assert property (@(posedge clk) disable iff (rst)
        (done_valid || fault_valid || size_err) |-> !busy);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $countones({done_valid, fault_valid, size_err}) <= 1);

    a_r7_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> mem_req_wdata[5]);
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .done_valid    (done_valid),
    .fault_valid   (fault_valid),
    .size_err      (size_err)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = 32'h0001_0000;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [31:0] done_entry;
    logic        fault_valid;
    logic        fault_prot;
    logic        fault_write;
    logic        fault_user;
    logic [31:0] fault_vaddr;
    logic        size_err;

    always #2.5 clk = ~clk;

    pt_walker u_dut (.*);

    typedef struct {
        bit        wr;
        bit [31:0] addr;
        bit [31:0] data;
        string     tag;
    } tx_t;

    logic [31:0] mem [logic [31:0]];
    tx_t         exp_q[$];
    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    int          rsp_cnt = 0;
    logic [31:0] rsp_data = '0;

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic cycle();
        tx_t t;
        @(negedge clk);
        cyc++;
        mem_rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = rsp_data;
            end
        end
        mem_req_ready = (cyc % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected memory request", {mem_req_write, mem_req_addr}, 64'h0);
            end else begin
                t = exp_q.pop_front();
                chk(t.tag, "request direction", mem_req_write, t.wr);
                chk(t.tag, "request address", mem_req_addr, t.addr);
                if (t.wr) chk(t.tag, "write data", mem_req_wdata, t.data);
            end
            if (mem_req_write) mem[mem_req_addr] = mem_req_wdata;
            else begin
                rsp_cnt  = 2;
                rsp_data = rd(mem_req_addr);
            end
        end
    endtask

    // kind: 0 done, 1 absent fault, 2 protection fault, 3 size error
    task automatic run_walk(logic [31:0] va, bit wr, bit usr, bit junk, string name);
        logic [31:0] pa, pde, pa2, pte, npte;
        int          e_kind;
        int          a_kind;
        logic [31:0] e_paddr = '0;
        logic [31:0] e_entry = '0;
        bit          got = 0;
        int          n = 0;
        tx_t         t;
        pa  = dir_base + {20'h0, va[31:22], 2'b00};
        pde = rd(pa);
        t = '{0, pa, 0, "R1"}; exp_q.push_back(t);
        if (!pde[0]) e_kind = 1;
        else if (pde[7]) e_kind = 3;
        else if ((usr && !pde[2]) || (wr && !pde[1])) e_kind = 2;
        else begin
            if (!pde[5]) begin t = '{1, pa, pde | 32'h20, "R6"}; exp_q.push_back(t); end
            pa2 = {pde[31:12], va[21:12], 2'b00};
            pte = rd(pa2);
            t = '{0, pa2, 0, "R2"}; exp_q.push_back(t);
            if (!pte[0]) e_kind = 1;
            else if ((usr && !pte[2]) || (wr && !pte[1])) e_kind = 2;
            else begin
                e_kind = 0;
                npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
                if (npte != pte) begin t = '{1, pa2, npte, "R7"}; exp_q.push_back(t); end
                e_paddr = {npte[31:12], va[11:0]};
                e_entry = npte;
            end
        end
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        cycle();
        req_valid = junk;
        if (junk) begin req_vaddr = va ^ 32'h0040_0000; req_write = ~wr; req_user = ~usr; end
        chk("R9", {name, " busy after accept"}, busy, 1);
        while (!got && n < 300) begin
            cycle();
            n++;
            got = done_valid || fault_valid || size_err;
            if (got) req_valid = 1'b0;
            else if (busy !== 1'b1) chk("R9", {name, " busy during walk"}, busy, 1);
        end
        req_valid = 1'b0;
        if (!got) begin
            chk("R9", {name, " walk timeout"}, 0, 1);
        end else begin
            a_kind = done_valid ? 0 : fault_valid ? (fault_prot ? 2 : 1) : 3;
            chk("R9", {name, " busy at result"}, busy, 0);
            chk(e_kind == 3 ? "R5" : e_kind == 0 ? "R8" : e_kind == 1 ? "R3" : "R4",
                {name, " outcome kind"}, a_kind, e_kind);
            if (e_kind == 0 && a_kind == 0) begin
                chk("R2", {name, " physical address"}, done_paddr, e_paddr);
                chk("R8", {name, " returned entry"}, done_entry, e_entry);
            end
            if (e_kind != 0 && a_kind == e_kind) begin
                chk(e_kind == 3 ? "R5" : "R3", {name, " fault address"}, fault_vaddr, va);
                if (e_kind != 3) chk("R4", {name, " access flags"}, {fault_write, fault_user}, {wr, usr});
            end
            cycle();
            chk("R8", {name, " result is one cycle"}, {done_valid, fault_valid, size_err}, 0);
        end
        chk("R7", {name, " all expected requests issued"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    function automatic logic [31:0] mk_va(int d, int t, int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    function automatic logic [31:0] pde_at(int d);
        return 32'h0001_0000 + d * 4;
    endfunction

    function automatic logic [31:0] pte_at(int d, int t);
        return 32'h0002_0000 + d * 32'h1000 + t * 4;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "reset busy", busy, 0);
        chk("R9", "reset memory request", mem_req_valid, 0);
        chk("R8", "reset result pulses", {done_valid, fault_valid, size_err}, 0);
        rst = 1'b0;

        for (int d = 1; d <= 11; d++) mem[pde_at(d)] = 32'h0002_0000 + d * 32'h1000 | 32'h27;
        mem[pte_at(1, 2)]  = 32'h0050_1000 | 32'h27;
        mem[pde_at(2)]     = 32'h0002_2000 | 32'h07;
        mem[pte_at(2, 5)]  = 32'h0050_2000 | 32'h07;
        mem[pte_at(3, 9)]  = 32'h0050_3000 | 32'h27;
        mem[pte_at(4, 1)]  = 32'h0050_4000 | 32'h67;
        mem[pde_at(5)]     = 32'h0000_0000;
        mem[pde_at(6)]     = 32'h0002_6000 | 32'h07;
        mem[pte_at(6, 3)]  = 32'h0050_6000 | 32'h26;
        mem[pte_at(7, 4)]  = 32'h0050_7000 | 32'h23;
        mem[pde_at(8)]     = 32'h0002_8000 | 32'h25;
        mem[pde_at(9)]     = 32'h0040_0000 | 32'hA7;
        mem[pde_at(10)]    = 32'h0040_0000 | 32'hA6;
        mem[pte_at(11, 7)] = 32'h0000_0020;

        run_walk(mk_va(1, 2, 12'h345), 0, 0, 0, "clean read");
        run_walk(mk_va(2, 5, 12'h0AB), 0, 1, 0, "accessed both levels");
        chk("R6", "directory accessed stored", rd(pde_at(2)), 32'h0002_2027);
        run_walk(mk_va(3, 9, 12'hFFF), 1, 0, 0, "write clean page");
        chk("R7", "table dirty stored", rd(pte_at(3, 9)), 32'h0050_3067);
        run_walk(mk_va(4, 1, 12'h000), 1, 1, 0, "write dirty page");
        run_walk(mk_va(5, 0, 12'h010), 0, 0, 0, "missing directory");
        run_walk(mk_va(6, 3, 12'h123), 1, 0, 0, "missing table entry");
        run_walk(mk_va(7, 4, 12'h456), 0, 1, 0, "user to supervisor");
        run_walk(mk_va(8, 0, 12'h789), 1, 0, 0, "write read-only dir");
        run_walk(mk_va(9, 0, 12'h000), 0, 0, 0, "large page");
        run_walk(mk_va(10, 0, 12'h000), 1, 1, 0, "absent large page");
        run_walk(mk_va(11, 7, 12'h222), 1, 1, 0, "absent forbidden");
        run_walk(mk_va(1, 2, 12'h001), 1, 1, 1, "write with held junk");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule